// File: doc/BRIEF.md
# Prioritized I/O Chip-Select Decoder

This block turns I/O-space bus cycles into one of several active-low chip-select lines for external devices. It compares address bits [15:8] against the 8-bit base value of each channel. The lowest-numbered qualifying channel is the only one selected. Any address that falls inside the fixed window reserved for on-chip peripherals is never passed to an external select. Each channel's control byte enables the channel, marks it as an I/O channel, and sets a wait count of 0 to 7 extra clocks. For those extra clocks the block holds the processor through a stall output.

A request is sampled on a rising clock edge while the block is idle. The select, the I/O strobe and the read or write strobe then go low together from that edge. They stay low for the base cycle plus the programmed wait cycles, and they return high on the clock that follows. Requests that arrive while an access is in progress are ignored.

Top module: `iocs_decoder`

## Requirements
- R1: A chip select is produced only when io_cycle is 1 at the sampling edge; memory cycles (io_cycle = 0) leave every cs_n high.
- R2: The match uses only addr[15:8] against the channel's base byte; addr[23:16] and addr[7:0] have no effect on which channel is selected.
- R3: When several channels qualify, only the lowest-numbered one is driven low, and at most one cs_n is ever low.
- R4: A channel qualifies only when its control bit 3 (enable) and bit 4 (I/O select) are both 1; with either bit clear its line stays high.
- R5: Addresses with addr[15:0] from 0080h to 00FFh select no channel, even when a channel's base byte is 00h.
- R6: During a decoded access the selected cs_n and iorq_n are low, and rd_n is low for a read while wr_n is low for a write; if rd_req and wr_req are both 1, the access is a read.
- R7: Control bits [7:5] give a wait count w; the select and strobes stay low for w+1 clocks, and stall is high for the first w of them.
- R8: With w = 0 the access lasts exactly one clock and stall never rises.
- R9: On the clock after the last cycle of an access, every cs_n, iorq_n, rd_n and wr_n is high and stall is low.
- R10: Requests presented while an access is in progress do not change the selected channel, the direction or the length of that access.
- R11: While rst_n is low, all active-low outputs are high and stall is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | ADDR_W | Bus address |
| io_cycle | input | 1 | 1 when the current bus cycle is in I/O space |
| rd_req | input | 1 | Read request |
| wr_req | input | 1 | Write request |
| ctl_flat | input | NUM_CH*8 | Control byte per channel: [7:5] wait count, [4] I/O select, [3] enable |
| base_flat | input | NUM_CH*8 | Base byte per channel, compared with addr[15:8] |
| cs_n | output | NUM_CH | Active-low chip selects |
| iorq_n | output | 1 | Active-low I/O request strobe |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| stall | output | 1 | Holds the processor during wait cycles |

## Verification
The bench targets several edges of the decode. It sets two channels to the same base byte; a priority encoder that is inverted or missing would then assert both lines or the higher-numbered line. It also probes both ends of the peripheral window and the address just below it with a channel based at 00h, where an off-by-one comparison would leak a select onto 0080h or 00FFh or block 007Fh. Wait counts of 0 and 7 show whether the counter loads late or counts one cycle too many. A stall that rises for a zero count is caught as well. Extra requests are injected during long accesses to expose a decoder that retriggers or switches channels in the middle of an access.

// File: rtl/iocs_pkg.sv
package iocs_pkg;
   localparam int CTL_W       = 8;
   localparam int BASE_W      = 8;
   localparam int WAIT_W      = 3;
   localparam int CTL_WAIT_LO = 5;
   localparam int CTL_IOSEL   = 4;
   localparam int CTL_EN      = 3;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_BUSY = 1'b1
   } bus_st_t;
endpackage

// File: rtl/iocs_chan_match.sv
module iocs_chan_match
   import iocs_pkg::*;
(
   input  logic              en,
   input  logic              iosel,
   input  logic [BASE_W-1:0] base,
   input  logic [BASE_W-1:0] addr_hi,
   output logic              hit
);
   assign hit = en & iosel & (base == addr_hi);
endmodule

// File: rtl/iocs_prio.sv
module iocs_prio #(
   parameter int N = 4
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] gnt,
   output logic         any
);
   always_comb begin
      logic taken;
      taken = 1'b0;
      gnt   = '0;
      for (int i = 0; i < N; i++) begin
         if (req[i] && !taken) begin
            gnt[i] = 1'b1;
            taken  = 1'b1;
         end
      end
      any = taken;
   end
endmodule

// File: rtl/iocs_wait_ctr.sv
module iocs_wait_ctr #(
   parameter int W = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic [W-1:0] cnt,
   output logic         zero
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt <= '0;
      else if (load)         cnt <= load_val;
      else if (cnt != '0)    cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);

   assert_wait_countdown_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/iocs_decoder.sv
module iocs_decoder
   import iocs_pkg::*;
#(
   parameter int          NUM_CH    = 4,
   parameter int          ADDR_W    = 24,
   parameter logic [15:0] PERIPH_LO = 16'h0080,
   parameter logic [15:0] PERIPH_HI = 16'h00FF
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [ADDR_W-1:0]        addr,
   input  logic                     io_cycle,
   input  logic                     rd_req,
   input  logic                     wr_req,
   input  logic [NUM_CH*CTL_W-1:0]  ctl_flat,
   input  logic [NUM_CH*BASE_W-1:0] base_flat,
   output logic [NUM_CH-1:0]        cs_n,
   output logic                     iorq_n,
   output logic                     rd_n,
   output logic                     wr_n,
   output logic                     stall
);
   localparam int IO_W = 16;

   if (NUM_CH < 1 || NUM_CH > 16) begin : g_bad_nch
      $error("iocs_decoder: NUM_CH must be 1..16");
   end
   if (ADDR_W < IO_W) begin : g_bad_aw
      $error("iocs_decoder: ADDR_W must be at least 16");
   end
   if (PERIPH_LO > PERIPH_HI) begin : g_bad_win
      $error("iocs_decoder: peripheral window is empty");
   end

   logic [NUM_CH-1:0] hit_vec, gnt;
   logic              any_hit;
   logic [IO_W-1:0]   io_addr;
   logic              periph, req_ok, start;
   logic [WAIT_W-1:0] wait_sel, cnt;
   logic              cnt_zero;
   bus_st_t           state;
   logic [NUM_CH-1:0] sel_q;
   logic              rd_q;

   assign io_addr = addr[IO_W-1:0];

   if (ADDR_W > IO_W) begin : g_hi_addr
      logic unused_hi;
      assign unused_hi = ^addr[ADDR_W-1:IO_W];
   end

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic [CTL_W-1:0] ctl_i;
      logic             unused_rsv;
      assign ctl_i      = ctl_flat[i*CTL_W +: CTL_W];
      assign unused_rsv = ^ctl_i[CTL_EN-1:0];
      iocs_chan_match u_match (
         .en      (ctl_i[CTL_EN]),
         .iosel   (ctl_i[CTL_IOSEL]),
         .base    (base_flat[i*BASE_W +: BASE_W]),
         .addr_hi (io_addr[15:8]),
         .hit     (hit_vec[i])
      );
   end

   iocs_prio #(.N(NUM_CH)) u_prio (
      .req (hit_vec),
      .gnt (gnt),
      .any (any_hit)
   );

   always_comb begin
      wait_sel = '0;
      for (int i = 0; i < NUM_CH; i++)
         if (gnt[i]) wait_sel |= ctl_flat[i*CTL_W + CTL_WAIT_LO +: WAIT_W];
   end

   assign periph = (io_addr >= PERIPH_LO) && (io_addr <= PERIPH_HI);
   assign req_ok = io_cycle && (rd_req || wr_req) && !periph;
   assign start  = (state == ST_IDLE) && req_ok && any_hit;

   iocs_wait_ctr #(.W(WAIT_W)) u_wait (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (start),
      .load_val (wait_sel),
      .cnt      (cnt),
      .zero     (cnt_zero)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         sel_q <= '0;
         rd_q  <= 1'b0;
      end else if (state == ST_IDLE) begin
         if (start) begin
            state <= ST_BUSY;
            sel_q <= gnt;
            rd_q  <= rd_req;
         end
      end else if (cnt_zero) begin
         state <= ST_IDLE;
         sel_q <= '0;
      end
   end

   assign cs_n   = ~sel_q;
   assign iorq_n = (state != ST_BUSY);
   assign rd_n   = !((state == ST_BUSY) && rd_q);
   assign wr_n   = !((state == ST_BUSY) && !rd_q);
   assign stall  = (state == ST_BUSY) && !cnt_zero;

   assert_io_only_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && !io_cycle) |=> (&cs_n));
   assert_single_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~cs_n));
   assert_periph_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && periph) |=> (&cs_n));
   assert_strobe_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ((&cs_n) == iorq_n) && (iorq_n || (rd_n != wr_n)));
   assert_stall_inside_R7: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> !iorq_n);
   assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!iorq_n && !stall) |=> (iorq_n && (&cs_n) && rd_n && wr_n));
   assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!iorq_n && stall) |=> (!iorq_n && $stable(cs_n) && $stable(rd_n)));
endmodule

// File: tb/iocs_decoder_tb.sv
`timescale 1ns/1ps
module iocs_decoder_tb;
   localparam int N = 4;

   logic            clk = 1'b0;
   logic            rst_n;
   logic [23:0]     addr;
   logic            io_cycle, rd_req, wr_req;
   logic [N*8-1:0]  ctl_flat, base_flat;
   logic [N-1:0]    cs_n;
   logic            iorq_n, rd_n, wr_n, stall;
   logic [7:0]      ctl_r  [N];
   logic [7:0]      base_r [N];
   int              n_chk = 0;
   int              n_bad = 0;
   bit              done  = 1'b0;

   always #4 clk = ~clk;

   always_comb begin
      for (int i = 0; i < N; i++) begin
         ctl_flat[i*8 +: 8]  = ctl_r[i];
         base_flat[i*8 +: 8] = base_r[i];
      end
   end

   iocs_decoder u_dut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .io_cycle(io_cycle),
      .rd_req(rd_req), .wr_req(wr_req), .ctl_flat(ctl_flat),
      .base_flat(base_flat), .cs_n(cs_n), .iorq_n(iorq_n),
      .rd_n(rd_n), .wr_n(wr_n), .stall(stall)
   );

   function automatic int exp_ch(logic [23:0] a, bit io, bit rd, bit wr);
      if (!io || !(rd || wr)) return -1;
      if (a[15:0] >= 16'h0080 && a[15:0] <= 16'h00FF) return -1;
      for (int i = 0; i < N; i++)
         if (ctl_r[i][3] && ctl_r[i][4] && base_r[i] == a[15:8]) return i;
      return -1;
   endfunction

   function automatic logic [N+3:0] exp_vec(int ch, bit is_rd, bit stl);
      logic [N-1:0] c;
      c = '1;
      if (ch < 0) return {c, 1'b1, 1'b1, 1'b1, 1'b0};
      c[ch] = 1'b0;
      return {c, 1'b0, !is_rd, is_rd, stl};
   endfunction

   task automatic check(string req, logic [N+3:0] exp);
      logic [N+3:0] act;
      act = {cs_n, iorq_n, rd_n, wr_n, stall};
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: {cs_n,iorq_n,rd_n,wr_n,stall} actual=%b expected=%b", req, act, exp);
      end
   endtask

   task automatic idle_bus();
      io_cycle = 1'b0; rd_req = 1'b0; wr_req = 1'b0; addr = '0;
   endtask

   task automatic access(logic [23:0] a, bit io, bit rd, bit wr, bit noise, string req);
      int ch;
      int w;
      ch = exp_ch(a, io, rd, wr);
      w  = (ch >= 0) ? int'(ctl_r[ch][7:5]) : 0;
      addr = a; io_cycle = io; rd_req = rd; wr_req = wr;
      if (ch < 0) begin
         @(negedge clk);
         check(req, exp_vec(-1, 1'b0, 1'b0));
         idle_bus();
         @(negedge clk);
         check(req, exp_vec(-1, 1'b0, 1'b0));
         return;
      end
      for (int k = 0; k <= w; k++) begin
         @(negedge clk);
         check(req, exp_vec(ch, rd, k < w));
         if (noise) begin
            addr = {$urandom_range(255, 0), base_r[N-1 - (k % N)], 8'h01};
            io_cycle = 1'b1; rd_req = !rd; wr_req = rd;
         end else begin
            idle_bus();
         end
      end
      @(negedge clk);
      check("R9", exp_vec(-1, 1'b0, 1'b0));
      idle_bus();
      @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED1234));
      rst_n = 1'b0;
      idle_bus();
      for (int i = 0; i < N; i++) begin ctl_r[i] = '0; base_r[i] = '0; end
      repeat (3) @(negedge clk);
      check("R11 reset", exp_vec(-1, 1'b0, 1'b0));
      rst_n = 1'b1;
      @(negedge clk);

      // R4: all channels cleared, nothing selects
      access(24'h000100, 1, 1, 0, 0, "R4 all disabled");
      base_r[0] = 8'h12; ctl_r[0] = 8'b000_0_1_000;     // enable only
      access(24'h001200, 1, 1, 0, 0, "R4 enable without I/O bit");
      ctl_r[0] = 8'b000_1_0_000;                        // I/O bit only
      access(24'h001200, 1, 1, 0, 0, "R4 I/O bit without enable");
      ctl_r[0] = 8'b000_1_1_000;
      access(24'h001234, 1, 1, 0, 0, "R8 wait0 read");
      access(24'h001234, 0, 1, 0, 0, "R1 memory cycle");
      access(24'hAB12FF, 1, 0, 1, 0, "R2 upper byte ignored write");
      access(24'h001234, 1, 1, 1, 0, "R6 read wins");
      // R3 priority: channels 1 and 2 share base 34
      base_r[1] = 8'h34; ctl_r[1] = 8'b010_1_1_000;
      base_r[2] = 8'h34; ctl_r[2] = 8'b101_1_1_000;
      access(24'h773456, 1, 0, 1, 0, "R3 lowest channel");
      ctl_r[1] = 8'b010_1_0_000;
      access(24'h003456, 1, 1, 0, 0, "R3 next channel after disable");
      // R5 window with a channel based at 00
      base_r[3] = 8'h00; ctl_r[3] = 8'b001_1_1_000;
      access(24'h000080, 1, 1, 0, 0, "R5 window low end");
      access(24'h0000FF, 1, 0, 1, 0, "R5 window high end");
      access(24'h00007F, 1, 1, 0, 0, "R5 just below window");
      // R7 maximum wait, R10 noise during access
      ctl_r[0] = 8'b111_1_1_000;
      access(24'h001200, 1, 0, 1, 0, "R7 wait7");
      access(24'h001200, 1, 1, 0, 1, "R10 requests during access");

      for (int n = 0; n < 400; n++) begin
         logic [7:0] pool [5];
         pool[0] = 8'h00; pool[1] = 8'h12; pool[2] = 8'h34;
         pool[3] = 8'hFF; pool[4] = 8'h5A;
         if ($urandom_range(3, 0) == 0) begin
            for (int i = 0; i < N; i++) begin
               base_r[i] = pool[$urandom_range(4, 0)];
               ctl_r[i]  = {3'($urandom_range(7, 0)), 2'($urandom_range(3, 1)), 3'b000};
            end
         end
         access({8'($urandom), pool[$urandom_range(4, 0)], 8'($urandom)},
                $urandom_range(7, 0) != 0, 1'($urandom), 1'($urandom),
                $urandom_range(3, 0) == 0, "R2/R3/R6/R7 random");
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule